// File: doc/BRIEF.md
# Input Change Wake Detector

This block keeps watch over a wide bundle of input lines while a device sleeps. On a sleep request it records a copy of the bundle, checks for one cycle that the bundle has not moved, and then goes to sleep. While it sleeps, a purely combinational comparison raises a wake request as soon as any line differs from the stored copy. No clock edge is needed for this, so the wake request can restart a stopped clock.

The comparison is made against the stored copy and not against a fixed level. Lines that normally sit high therefore do not wake the device. After the clock runs again, the wake request passes through a two-stage synchronizer before the control logic leaves the sleep state. While the device is awake, the wake request is held low.

Top module: `input_change_waker`

## Requirements
- R1: While `rst_ni` is low, `asleep_o` and `wake_o` are 0.
- R2: While the block is awake and no sleep request was sampled on the previous edge, `wake_o` stays 0 for any change of `watch_i`.
- R3: When `sleep_req_i` is high at a rising edge while awake, `watch_i` is stored. `asleep_o` stays 0 after that edge and rises after the next edge, provided `watch_i` still equals the stored value at that edge.
- R4: While asleep, `wake_o` is 1 in the same time step, with no clock edge, whenever any bit of `watch_i` differs from the stored value. This includes bit 0, bit 65 and interior bits.
- R5: Inputs held at all ones while asleep do not raise `wake_o`, and `asleep_o` stays 1.
- R6: A change seen on `wake_o` while asleep clears `asleep_o` after the third rising edge, through a two-flop synchronizer. `asleep_o` is still 1 after the first and second edges.
- R7: If `watch_i` differs from the stored value during the cycle after capture, `wake_o` is 1 in that cycle, `asleep_o` never rises, and the block returns awake.
- R8: Once the block has woken, `wake_o` returns to 0 even though `watch_i` still differs from the stored value.
- R9: Asserting `rst_ni` low while asleep clears `asleep_o` at once, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, may be stopped while asleep |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sleep_req_i | input | 1 | Request to store inputs and enter sleep |
| watch_i | input | 66 | Watched input bundle |
| wake_o | output | 1 | Combinational change indication, masked while awake |
| asleep_o | output | 1 | Registered sleep status |

## Verification
The assertions assume that `sleep_req_i` is a clean synchronous level that is 0 out of reset. They also assume that any change that wakes the block stays in place until the synchronizer has carried it through. The latency and capture checks depend on both of these. The stimulus drives every input on the falling clock edge and lowers `sleep_req_i` one cycle after raising it. It also holds each waking change for at least three edges before it moves the bundle again.

// File: rtl/wake_pkg.sv
package wake_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE = 2'd0,
    ST_ARM   = 2'd1,
    ST_SLEEP = 2'd2
  } wake_state_e;
endpackage

// File: rtl/snap_reg.sv
module snap_reg #(
  parameter int W = 66
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (cap_i) q_o <= d_i;
  end
endmodule

// File: rtl/vec_diff.sv
// Clock-free compare, reduced per lane then across lanes.
module vec_diff #(
  parameter int W    = 66,
  parameter int LANE = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         diff_o
);
  localparam int LANES = (W + LANE - 1) / LANE;
  localparam int PW    = LANES * LANE;

  logic [PW-1:0]    a_pad, b_pad;
  logic [LANES-1:0] lane_diff;

  always_comb begin
    a_pad = '0;
    b_pad = '0;
    a_pad[W-1:0] = a_i;
    b_pad[W-1:0] = b_i;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_diff[g] = |(a_pad[g*LANE +: LANE] ^ b_pad[g*LANE +: LANE]);
  end

  assign diff_o = |lane_diff;
endmodule

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      pipe_q[s] <= 1'b0;
      else if (flush_i) pipe_q[s] <= 1'b0;
      else if (s == 0)  pipe_q[s] <= d_i;
      else              pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/input_change_waker.sv
module input_change_waker
  import wake_pkg::*;
#(
  parameter int W          = 66,
  parameter int LANE       = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sleep_req_i,
  input  logic [W-1:0] watch_i,
  output logic         wake_o,
  output logic         asleep_o
);
  wake_state_e state_q, state_d;
  logic [W-1:0] snap;
  logic         diff, cap, wake_sync_q, asleep_q;

  snap_reg #(.W(W)) u_snap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cap_i (cap),
    .d_i   (watch_i),
    .q_o   (snap)
  );

  vec_diff #(.W(W), .LANE(LANE)) u_diff (
    .a_i   (watch_i),
    .b_i   (snap),
    .diff_o(diff)
  );

  // Unmasked while arming or asleep; no clock on this path.
  assign wake_o = (state_q != ST_AWAKE) & diff;

  wake_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(state_q == ST_AWAKE),
    .d_i    (wake_o),
    .q_o    (wake_sync_q)
  );

  always_comb begin
    state_d = state_q;
    cap     = 1'b0;
    unique case (state_q)
      ST_AWAKE: if (sleep_req_i) begin
        state_d = ST_ARM;
        cap     = 1'b1;
      end
      ST_ARM:   state_d = diff ? ST_AWAKE : ST_SLEEP;
      ST_SLEEP: if (wake_sync_q) state_d = ST_AWAKE;
      default:  state_d = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_AWAKE;
      asleep_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      asleep_q <= (state_d == ST_SLEEP);
    end
  end

  assign asleep_o = asleep_q;
endmodule

// File: rtl/wake_chk.sv
module wake_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sleep_req_i,
  input logic wake_o,
  input logic asleep_o
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!asleep_o && !wake_o));

  // R2
  awake_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!asleep_o && !$past(sleep_req_i)) |-> !wake_o);

  // R3
  sleep_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(asleep_o) |-> $past(sleep_req_i, 2));

  // R7
  arm_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(asleep_o) |-> !$past(wake_o));

  // R6
  sync_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(asleep_o) |-> $past(wake_o, 3));
endmodule

bind input_change_waker wake_chk u_wake_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sleep_req_i(sleep_req_i),
  .wake_o     (wake_o),
  .asleep_o   (asleep_o)
);

// File: tb/sim_input_change_waker.sv
module sim_input_change_waker;
  localparam int  W      = 66;
  localparam time PERIOD = 10ns;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         sleep_req_i = 1'b0;
  logic [W-1:0] watch_i = '0;
  logic         wake_o, asleep_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  input_change_waker u0 (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sleep_req_i(sleep_req_i),
    .watch_i    (watch_i),
    .wake_o     (wake_o),
    .asleep_o   (asleep_o)
  );

  always #(PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    sleep_req_i = 1'b0;
    repeat (2) @(negedge clk_i);
    #1;
    check("R1 asleep in reset", int'(asleep_o), 0);
    check("R1 wake in reset", int'(wake_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // Raise sleep request for one edge with bundle v; ends asleep.
  task automatic enter_sleep(input logic [W-1:0] v);
    @(negedge clk_i);
    watch_i = v;
    sleep_req_i = 1'b1;
    @(negedge clk_i);
    sleep_req_i = 1'b0;
    #1 check("R3 not asleep after capture edge", int'(asleep_o), 0);
    @(negedge clk_i);
    #1 check("R3 asleep after second edge", int'(asleep_o), 1);
  endtask

  task automatic t_awake_mask();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      watch_i = {W{1'b1}} >> (i * 7);
      #1 check("R2 masked while awake", int'(wake_o), 0);
    end
  endtask

  task automatic t_single_bit(input int pos);
    logic [W-1:0] base;
    base = {W{1'b0}} | 66'h2_5A5A_0F0F_3C3C_9696;
    enter_sleep(base);
    @(negedge clk_i);
    watch_i = base ^ (66'd1 << pos);
    #1 check($sformatf("R4 wake on bit %0d", pos), int'(wake_o), 1);
    check("R4 still asleep before edge", int'(asleep_o), 1);
    @(negedge clk_i);
    check("R6 asleep after edge 1", int'(asleep_o), 1);
    @(negedge clk_i);
    check("R6 asleep after edge 2", int'(asleep_o), 1);
    @(negedge clk_i);
    check("R6 awake after edge 3", int'(asleep_o), 0);
    check("R8 wake masked after waking", int'(wake_o), 0);
  endtask

  task automatic t_high_inputs();
    enter_sleep({W{1'b1}});
    repeat (6) @(negedge clk_i);
    #1 check("R5 no wake on steady ones", int'(wake_o), 0);
    check("R5 stays asleep", int'(asleep_o), 1);
    watch_i[40] = 1'b0;
    #1 check("R4 wake on bit 40", int'(wake_o), 1);
    repeat (3) @(negedge clk_i);
    check("R6 woke after three edges", int'(asleep_o), 0);
  endtask

  task automatic t_arm_change();
    @(negedge clk_i);
    watch_i = 66'h1_0000_0000_0000_0001;
    sleep_req_i = 1'b1;
    @(negedge clk_i);
    sleep_req_i = 1'b0;
    watch_i = 66'h1_0000_0000_0000_0003;
    #1 check("R7 wake in arm cycle", int'(wake_o), 1);
    repeat (3) begin
      @(negedge clk_i);
      #1 check("R7 never asleep", int'(asleep_o), 0);
    end
    check("R7 wake low once awake", int'(wake_o), 0);
  endtask

  task automatic t_async_reset();
    enter_sleep(66'h0_FFFF_0000_FFFF_0000);
    @(negedge clk_i);
    #2 rst_ni = 1'b0;
    #1 check("R9 async clear of asleep", int'(asleep_o), 0);
    check("R1 wake low in reset", int'(wake_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    do_reset();
    t_awake_mask();
    t_single_bit(0);
    t_single_bit(65);
    t_single_bit(33);
    t_high_inputs();
    t_arm_change();
    t_async_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule